// File: doc/BRIEF.md
# Acknowledge Polling Sequencer for an I2C Master

This block is the master-side controller that runs once a write to a slave memory has been committed by a STOP. While the slave performs its internal nonvolatile write, it ignores its own address. The sequencer therefore probes it over and over until it answers. Each probe is an attempt: a START followed by the slave address byte, with a read or write direction bit. If the address byte is not acknowledged, the slave is still busy, so the sequencer sends STOP and makes another attempt.

When an attempt is acknowledged, the sequencer samples the host's continue flag. If the flag is set, the transfer is left open with no STOP, so the host's next read or write can go on from there. If the flag is clear, the sequencer closes the bus with STOP. A parameter sets the maximum number of attempts. When every attempt goes unanswered, the sequencer closes the bus and reports an error.

The sequencer does not drive SCL or SDA itself. It commands a byte-level master engine through a request/acknowledge handshake, and that engine produces the bit-level waveforms.

States: `ST_IDLE`, `ST_START`, `ST_ADDR`, `ST_STOP_RETRY`, `ST_STOP_END`, `ST_STOP_FAIL`, `ST_DONE`. Transitions:
- `ST_IDLE` to `ST_START` on `go`.
- `ST_START` to `ST_ADDR` on engine ack.
- `ST_ADDR` moves on engine ack:
  - to `ST_DONE` if the byte was acknowledged and `cont` is 1;
  - to `ST_STOP_END` if the byte was acknowledged and `cont` is 0;
  - to `ST_STOP_RETRY` if the byte was not acknowledged and attempts remain;
  - to `ST_STOP_FAIL` if the byte was not acknowledged on the last attempt.
- `ST_STOP_RETRY` to `ST_START` on engine ack.
- `ST_STOP_END` and `ST_STOP_FAIL` to `ST_DONE` on engine ack.
- `ST_DONE` to `ST_IDLE` always.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `open` and `eng_req` are all 0.
- R2: A `go` pulse in idle latches `slave_addr` and `dir_rd`. The byte sent to the engine is {slave_addr[6:0], dir_rd}, with bit 0 = 1 meaning read.
- R3: Each attempt requests START and then a byte carrying the latched address byte. Command codes on `eng_cmd` are 0 = START, 1 = BYTE and 2 = STOP. `eng_req`, `eng_cmd` and `eng_wdata` stay steady until `eng_ack`.
- R4: When the address byte ends with `eng_nack` = 1 and attempts remain, the sequencer requests STOP and then begins a new attempt with START.
- R5: When the address byte ends with `eng_nack` = 0 and `cont` = 1, no STOP is requested. `done` pulses with `open` = 1 and `err` = 0.
- R6: When the address byte ends with `eng_nack` = 0 and `cont` = 0, the sequencer requests STOP. After that STOP completes, `done` pulses with `open` = 0 and `err` = 0.
- R7: If MAX_TRIES attempts in a row end with `eng_nack` = 1, the sequencer requests STOP and then pulses `done` with `err` = 1 and `open` = 0. It never makes more than MAX_TRIES attempts.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after `go` until the cycle before `done`, and is 0 while `done` is high.
- R9: While `busy` is high, a `go` pulse and any changes to `slave_addr` or `dir_rd` have no effect on the command sequence.
- R10: `err` and `open` keep their values after `done` until the next accepted `go`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Host start pulse |
| dir_rd | input | 1 | Poll direction, 1 = read; latched at go |
| slave_addr | input | 7 | 7-bit slave address; latched at go |
| cont | input | 1 | Host wants to continue on the open transfer; sampled on ACK |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Attempt limit reached without ACK |
| open | output | 1 | Transfer left open with no STOP |
| eng_req | output | 1 | Command request to the byte engine |
| eng_cmd | output | 2 | Command: 0 START, 1 BYTE, 2 STOP |
| eng_wdata | output | 8 | Byte to send for BYTE |
| eng_ack | input | 1 | Engine completed the current command (one-cycle) |
| eng_nack | input | 1 | With eng_ack on BYTE: 1 = slave did not acknowledge |

## Verification
The assertions check, on every cycle, the cycle-level rules:
- the request stays steady until the engine accepts it;
- no request is made while idle or while the transfer is left open;
- `done` lasts a single cycle and never overlaps `busy`;
- `err` rises only with `done`;
- the attempt counter stays below its limit;
- the latched address byte does not change during a run.

Only the bench scenarios can show that the command sequence is right as a whole. These cover immediate acknowledgement, several busy attempts, exhaustion of the limit with an error, the open-versus-closed ending chosen by `cont`, and that mid-run `go` pulses and input changes leave no trace.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_BYTE  = 2'd1,
        ENG_STOP  = 2'd2
    } eng_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_STOP_RETRY,
        ST_STOP_END,
        ST_STOP_FAIL,
        ST_DONE
    } poll_state_e;

endpackage

// File: rtl/ackpoll_try_ctr.sv
module ackpoll_try_ctr #(
    parameter int MAX_TRIES = 8,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_TRIES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    assign at_last = (count == LAST);

endmodule

// File: rtl/ackpoll_addr_latch.sv
module ackpoll_addr_latch #(
    parameter int ADDR_W = 7,
    parameter int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output logic [BYTE_W-1:0] byte_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o <= '0;
        end else if (load) begin
            byte_o <= {addr, rd};
        end
    end

endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
    import ackpoll_pkg::*;
#(
    parameter int MAX_TRIES = 8,
    parameter int ADDR_W    = 7,
    parameter int BYTE_W    = ADDR_W + 1,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              dir_rd,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic              cont,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              open,
    output logic              eng_req,
    output logic [1:0]        eng_cmd,
    output logic [BYTE_W-1:0] eng_wdata,
    input  logic              eng_ack,
    input  logic              eng_nack
);

    poll_state_e      state, state_nx;
    logic             accept;
    logic             addr_acked;
    logic             addr_nacked;
    logic [CNT_W-1:0] tries;
    logic             last_try;

    // A go pulse is taken only in idle; in any other state it is ignored (R9).
    assign accept      = go && (state == ST_IDLE);
    assign addr_acked  = (state == ST_ADDR) && eng_ack && !eng_nack;
    assign addr_nacked = (state == ST_ADDR) && eng_ack && eng_nack;

    ackpoll_addr_latch #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .addr   (slave_addr),
        .rd     (dir_rd),
        .byte_o (eng_wdata)
    );

    ackpoll_try_ctr #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_tries (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (addr_nacked && !last_try),
        .count   (tries),
        .at_last (last_try)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (accept) state_nx = ST_START;
            ST_START:      if (eng_ack) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (addr_acked) begin
                    state_nx = cont ? ST_DONE : ST_STOP_END;
                end else if (addr_nacked) begin
                    state_nx = last_try ? ST_STOP_FAIL : ST_STOP_RETRY;
                end
            end
            ST_STOP_RETRY: if (eng_ack) state_nx = ST_START;
            ST_STOP_END:   if (eng_ack) state_nx = ST_DONE;
            ST_STOP_FAIL:  if (eng_ack) state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Result flags, held until the next accepted go
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err  <= 1'b0;
            open <= 1'b0;
        end else if (accept) begin
            err  <= 1'b0;
            open <= 1'b0;
        end else begin
            if (state == ST_STOP_FAIL && eng_ack) err <= 1'b1;
            if (addr_acked && cont) open <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        eng_req = 1'b0;
        eng_cmd = ENG_START;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_START: begin
                eng_req = 1'b1;
                eng_cmd = ENG_START;
            end
            ST_ADDR: begin
                eng_req = 1'b1;
                eng_cmd = ENG_BYTE;
            end
            ST_STOP_RETRY, ST_STOP_END, ST_STOP_FAIL: begin
                eng_req = 1'b1;
                eng_cmd = ENG_STOP;
            end
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/ackpoll_chk.sv
module ackpoll_chk #(
    parameter int MAX_TRIES = 8,
    parameter int BYTE_W    = 8,
    parameter int CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              open,
    input logic              eng_req,
    input logic [1:0]        eng_cmd,
    input logic [BYTE_W-1:0] eng_wdata,
    input logic              eng_ack,
    input logic [CNT_W-1:0]  tries
);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_cmd) && $stable(eng_wdata)));

    p_cmd_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (eng_cmd != 2'd3));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_req);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_err_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    p_open_no_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> !eng_req);

    p_open_not_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(open && err));

    p_tries_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tries < CNT_W'(MAX_TRIES));

    p_byte_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(eng_wdata));

endmodule

bind ackpoll_seq ackpoll_chk #(
    .MAX_TRIES (MAX_TRIES),
    .BYTE_W    (BYTE_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .open      (open),
    .eng_req   (eng_req),
    .eng_cmd   (eng_cmd),
    .eng_wdata (eng_wdata),
    .eng_ack   (eng_ack),
    .tries     (tries)
);

// File: tb/tb_ackpoll_seq.sv
module tb_ackpoll_seq;

    localparam int MAXT    = 4;
    localparam int ENG_LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic       dir_rd = 1'b0;
    logic [6:0] slave_addr = '0;
    logic       cont = 1'b0;
    logic       busy, done, err, open, eng_req;
    logic [1:0] eng_cmd;
    logic [7:0] eng_wdata;
    logic       eng_ack = 1'b0;
    logic       eng_nack = 1'b0;

    int tests = 0;
    int fails = 0;
    int nack_left = 0;
    logic [9:0] expq[$];

    always #10 clk = ~clk;

    ackpoll_seq #(.MAX_TRIES(MAXT)) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .dir_rd(dir_rd),
        .slave_addr(slave_addr), .cont(cont), .busy(busy), .done(done),
        .err(err), .open(open), .eng_req(eng_req), .eng_cmd(eng_cmd),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_nack(eng_nack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Byte engine model: answers each request after ENG_LAT cycles
    initial begin
        forever begin
            @(negedge clk);
            if (eng_ack) begin
                eng_ack = 1'b0;
            end else if (eng_req) begin
                repeat (ENG_LAT) @(negedge clk);
                eng_nack = 1'b0;
                if (eng_cmd == 2'd1 && nack_left > 0) begin
                    eng_nack = 1'b1;
                    nack_left--;
                end
                eng_ack = 1'b1;
            end
        end
    end

    // Monitor: compares each completed command with the scoreboard (R3)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (eng_ack && eng_req) begin
                if (expq.size() == 0) begin
                    check("R3 unexpected command", {22'd0, eng_cmd, eng_wdata}, 32'h3ff);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    check("R3 command/byte", {22'd0, eng_cmd, eng_wdata}, {22'd0, e});
                end
            end
        end
    end

    // Driver: pushes expected commands, starts a poll and checks the result
    task automatic run_poll(input logic [6:0] a, input logic rd, input logic c,
                            input int nacks, input bit disturb,
                            input logic exp_err, input logic exp_open);
        int attempts;
        int wait_cnt;
        logic [7:0] b;
        b = {a, rd};
        attempts = (nacks + 1 > MAXT) ? MAXT : nacks + 1;
        for (int i = 0; i < attempts; i++) begin
            expq.push_back({2'd0, b});
            expq.push_back({2'd1, b});
            if (i < nacks) expq.push_back({2'd2, b});
        end
        if (nacks < MAXT && !c) expq.push_back({2'd2, b});
        nack_left = nacks;
        @(negedge clk);
        slave_addr = a;
        dir_rd = rd;
        cont = c;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R8 busy after go", {31'd0, busy}, 32'd1);
        check("R10 flags cleared by go", {30'd0, err, open}, 32'd0);
        if (disturb) begin
            repeat (5) @(negedge clk);
            slave_addr = ~a;
            dir_rd = ~rd;
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        wait_cnt = 0;
        while (!done && wait_cnt < 2000) begin
            @(negedge clk);
            wait_cnt++;
        end
        check("R8 done reached", {31'd0, done}, 32'd1);
        check("R8 busy low with done", {31'd0, busy}, 32'd0);
        check(exp_err ? "R7 err flag" : "R6 err flag", {31'd0, err}, {31'd0, exp_err});
        check(exp_open ? "R5 open flag" : "R6 open flag", {31'd0, open}, {31'd0, exp_open});
        @(negedge clk);
        check("R8 done one cycle", {31'd0, done}, 32'd0);
        check("R10 flags held", {30'd0, err, open}, {30'd0, exp_err, exp_open});
        check("R9 scoreboard drained", expq.size(), 32'd0);
        check("R5 no request after done", {31'd0, eng_req}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {27'd0, busy, done, err, open, eng_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, busy, eng_req}, 32'd0);
        // R2 R6: immediate ACK, write direction, close bus
        run_poll(7'h50, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0);
        // R4 R5: busy slave, read direction, continue open
        run_poll(7'h2b, 1'b1, 1'b1, 3, 1'b0, 1'b0, 1'b1);
        // R10: new go clears open; R7 limit exhausted
        run_poll(7'h11, 1'b0, 1'b1, MAXT, 1'b0, 1'b1, 1'b0);
        // R7 boundary: ACK on the final allowed attempt
        run_poll(7'h7f, 1'b1, 1'b0, MAXT - 1, 1'b0, 1'b0, 1'b0);
        // R9: go and input changes mid-run ignored
        run_poll(7'h35, 1'b0, 1'b0, 2, 1'b1, 1'b0, 1'b0);
        run_poll(7'h0a, 1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule